// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Subset Core

This core runs a small 32-bit load/store instruction subset and completes every instruction in one clock. The subset is word load, word store, add, subtract, AND, OR, signed set-less-than, branch-if-equal and jump. The core holds a 32-bit program counter, a 32-entry register file, and separate instruction and data memories built as small internal arrays. The decode is split into two levels. A main decoder turns the opcode into datapath controls and a 2-bit ALU class. A second decoder combines that class with the function field of register-format words to choose a 4-bit ALU operation.

Before reset is released, the surrounding logic or the bench fills the memories through a preload port. After release the core fetches from address 0. A set of observation ports shows every register write-back, every data-memory write and the current PC, so the core's architectural effect can be followed cycle by cycle. Reset is asserted asynchronously and released synchronously. While it is held, the PC stays at 0 and the core writes neither the register file nor data memory.

Top module: `sc_core`

## Requirements
- R1: While reset is held and on the first executing cycle, the PC reads 0, and no register or data-memory write is signalled during reset.
- R2: An instruction that does not redirect control advances the PC by 4 at the next rising edge. All architectural state changes on rising edges only.
- R3: An opcode of 0 selects a register-format operation from bits [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). Sources are [25:21] and [20:16] and the destination is [15:11].
- R4: Opcode 35 loads the data word at rs + sign-extended [15:0] into register [20:16].
- R5: Opcode 43 stores register [20:16] to the data word at rs + sign-extended [15:0] and writes no register.
- R6: Opcode 4 compares rs and rt by subtraction. When they are equal the next PC is PC+4 + (sign-extended [15:0] << 2); otherwise it is PC+4. Both backward and forward offsets are covered.
- R7: Opcode 2 sets the next PC to {PC+4 bits [31:28], instruction [25:0], 2'b00}.
- R8: Register 0 always reads as zero, and a write aimed at it leaves it zero.
- R9: An unlisted opcode, or opcode 0 with an unlisted function code, writes neither a register nor data memory and advances the PC by 4.
- R10: Loads and stores always add, and branches always subtract, whatever the low six bits of their offset look like as a function code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_we | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | 6 | Preload word index |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write-back this cycle |
| rf_waddr_o | output | 5 | Write-back register number |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data-memory store this cycle |
| dm_addr_o | output | 32 | Store byte address |
| dm_wdata_o | output | 32 | Store value |

## Verification
The main decoder and the function-field decoder look at the same instruction bits in the same cycle. A load, store or branch whose offset ends in a pattern that is also a valid function code (0x22, 0x2A, 0x25) is the case where the second decoder could take over by mistake. The bench places such offsets in the program on purpose. It judges them by the effective address and the branch outcome its own model predicts, since a wrong ALU operation moves the address or changes the outcome. A register write to r0 followed by a read of r0 in the same program checks R8 through the values that later instructions write back.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XW = 32;
  localparam int RFW = 5;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_LOAD = 6'd35;
  localparam logic [5:0] OP_STOR = 6'd43;
  localparam logic [5:0] OP_BREQ = 6'd4;
  localparam logic [5:0] OP_JUMP = 6'd2;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10,
    CLS_NONE = 2'b11
  } alu_cls_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_op_e;

  typedef struct packed {
    logic     reg_we;
    logic     dst_rd;
    logic     src_imm;
    logic     mem_we;
    logic     mem_rd;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
  } ctl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl,
  output alu_op_e    alu_op,
  output logic       bad
);
  ctl_t main_c;
  logic op_bad;
  logic fn_bad;

  // first level: opcode to datapath controls and ALU class
  always_comb begin
    main_c = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, mem_we: 1'b0,
               mem_rd: 1'b0, branch: 1'b0, jump: 1'b0, cls: CLS_NONE};
    op_bad = 1'b0;
    unique case (opcode)
      OP_REG: begin
        main_c.reg_we = 1'b1;
        main_c.dst_rd = 1'b1;
        main_c.cls    = CLS_FUNC;
      end
      OP_LOAD: begin
        main_c.reg_we  = 1'b1;
        main_c.src_imm = 1'b1;
        main_c.mem_rd  = 1'b1;
        main_c.cls     = CLS_ADD;
      end
      OP_STOR: begin
        main_c.src_imm = 1'b1;
        main_c.mem_we  = 1'b1;
        main_c.cls     = CLS_ADD;
      end
      OP_BREQ: begin
        main_c.branch = 1'b1;
        main_c.cls    = CLS_SUB;
      end
      OP_JUMP: main_c.jump = 1'b1;
      default: op_bad = 1'b1;
    endcase
  end

  // second level: class plus function field to ALU operation
  always_comb begin
    alu_op = ALU_ADD;
    fn_bad = 1'b0;
    unique case (main_c.cls)
      CLS_ADD: alu_op = ALU_ADD;
      CLS_SUB: alu_op = ALU_SUB;
      CLS_FUNC: begin
        unique case (funct)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: fn_bad = 1'b1;
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end

  always_comb begin
    ctl        = main_c;
    ctl.reg_we = main_c.reg_we & ~fn_bad;
    bad        = op_bad | fn_bad;
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    y = '0;
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_NOR: y = ~(a | b);
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] rv [NREG];

  // entry 0 has no storage and is tied to zero
  assign rv[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [W-1:0] q;
    logic         en;
    assign en = we && (wa == AW'(i));
    always_ff @(posedge clk) begin
      if (en) q <= wd;
    end
    assign rv[i] = q;
  end

  assign rd1 = rv[ra1];
  assign rd2 = rv[ra2];
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wa,
  input  logic [W-1:0]             wd,
  input  logic [$clog2(DEPTH)-1:0] ra,
  output logic [W-1:0]             rd
);
  logic [W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[wa] <= wd;
  end

  assign rd = arr[ra];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_we,
  input  logic        ld_dmem,
  input  logic [((($clog2(IMEM_WORDS)) > ($clog2(DMEM_WORDS))) ? $clog2(IMEM_WORDS) : $clog2(DMEM_WORDS))-1:0] ld_addr,
  input  logic [31:0] ld_data,
  output logic [31:0] pc_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  // reset: asynchronous assertion, release through two flops
  logic [1:0] rst_sync;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign run = rst_sync[1];

  // program counter
  logic [XW-1:0] pc_q, pc_d, pc4, br_tgt, jmp_tgt;

  always_ff @(posedge clk or negedge run) begin
    if (!run) pc_q <= '0;
    else      pc_q <= pc_d;
  end

  // fetch
  logic [XW-1:0] instr;
  logic          im_we;

  assign im_we = ld_we & ~ld_dmem;

  sc_mem #(.W(XW), .DEPTH(IMEM_WORDS)) u_imem (
    .clk (clk),
    .we  (im_we),
    .wa  (ld_addr[IAW-1:0]),
    .wd  (ld_data),
    .ra  (pc_q[IAW+1:2]),
    .rd  (instr)
  );

  // field split
  logic [5:0]     f_op, f_fn;
  logic [RFW-1:0] f_rs, f_rt, f_rd;
  logic [XW-1:0]  sext;

  assign f_op = instr[31:26];
  assign f_rs = instr[25:21];
  assign f_rt = instr[20:16];
  assign f_rd = instr[15:11];
  assign f_fn = instr[5:0];
  assign sext = {{(XW-16){instr[15]}}, instr[15:0]};

  // decode
  ctl_t    ctl;
  alu_op_e alu_op;
  logic    bad;

  sc_ctrl u_ctrl (
    .opcode (f_op),
    .funct  (f_fn),
    .ctl    (ctl),
    .alu_op (alu_op),
    .bad    (bad)
  );

  // register file
  logic [XW-1:0]  rs_val, rt_val, wb_data;
  logic [RFW-1:0] wb_addr;
  logic           wb_en;

  assign wb_addr = ctl.dst_rd ? f_rd : f_rt;
  assign wb_en   = run & ctl.reg_we;

  sc_regfile #(.W(XW), .NREG(1 << RFW)) u_rf (
    .clk (clk),
    .we  (wb_en),
    .wa  (wb_addr),
    .wd  (wb_data),
    .ra1 (f_rs),
    .ra2 (f_rt),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  // execute
  logic [XW-1:0] alu_b, alu_y;
  logic          alu_z;

  assign alu_b = ctl.src_imm ? sext : rt_val;

  sc_alu #(.W(XW)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_z)
  );

  // data memory, shared with the preload port
  logic           st_en, dm_we;
  logic [DAW-1:0] dm_wa;
  logic [XW-1:0]  dm_wd, dm_rd;

  assign st_en = run & ctl.mem_we;
  assign dm_we = st_en | (ld_we & ld_dmem);
  assign dm_wa = (ld_we & ld_dmem) ? ld_addr[DAW-1:0] : alu_y[DAW+1:2];
  assign dm_wd = (ld_we & ld_dmem) ? ld_data : rt_val;

  sc_mem #(.W(XW), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk (clk),
    .we  (dm_we),
    .wa  (dm_wa),
    .wd  (dm_wd),
    .ra  (alu_y[DAW+1:2]),
    .rd  (dm_rd)
  );

  assign wb_data = ctl.mem_rd ? dm_rd : alu_y;

  // next PC
  logic take_br;

  assign pc4     = pc_q + 32'd4;
  assign br_tgt  = pc4 + {sext[XW-3:0], 2'b00};
  assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};
  assign take_br = ctl.branch & alu_z;

  always_comb begin
    if (ctl.jump)     pc_d = jmp_tgt;
    else if (take_br) pc_d = br_tgt;
    else              pc_d = pc4;
  end

  // observation
  assign pc_o       = pc_q;
  assign rf_we_o    = wb_en;
  assign rf_waddr_o = wb_addr;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = st_en;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (pc_q == '0));

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (!run)
    (!ctl.jump && !take_br) |=> (pc_q == $past(pc_q) + 32'd4));

  // R6
  beq_tgt_chk: assert property (@(posedge clk) disable iff (!run)
    (ctl.branch && (rs_val == rt_val)) |=>
      (pc_q == $past(pc_q) + 32'd4 + ($past(sext) << 2)));

  // R7
  jmp_tgt_chk: assert property (@(posedge clk) disable iff (!run)
    ctl.jump |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!run)
    (f_rs == '0) |-> (rs_val == '0));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!run)
    bad |-> (!rf_we_o && !dm_we_o));

  // R10
  memop_add_chk: assert property (@(posedge clk) disable iff (!run)
    (ctl.mem_we || ctl.mem_rd) |-> (alu_op == ALU_ADD));
endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_we, ld_dmem;
  logic [5:0]  ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;

  int total = 0;
  int bad_n = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  // reference state
  logic [31:0] m_im [64];
  logic [31:0] m_dm [64];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;

  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare the current cycle against the model, then advance the model
  task automatic step_cmp();
    logic [31:0] ins, sx, a, b, npc, pc4, wd, addr;
    logic [5:0]  op, fn;
    int          rs, rt, rd, wa;
    bit          we, st, ctl_flow;
    string       tag;
    ins = m_im[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    sx = {{16{ins[15]}}, ins[15:0]};
    a = m_rf[rs]; b = m_rf[rt];
    pc4 = m_pc + 4; npc = pc4;
    we = 0; st = 0; wa = 0; wd = 0; addr = 0; ctl_flow = 0;
    tag = "R9";
    case (op)
      6'd0: begin
        tag = (rd == 0 || rs == 0) ? "R8" : "R3";
        we = 1; wa = rd;
        case (fn)
          6'h20: wd = a + b;
          6'h22: wd = a - b;
          6'h24: wd = a & b;
          6'h25: wd = a | b;
          6'h2A: wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin we = 0; tag = "R9"; end
        endcase
      end
      6'd35: begin tag = "R4/R10"; addr = a + sx; we = 1; wa = rt; wd = m_dm[addr[7:2]]; end
      6'd43: begin tag = "R5/R10"; addr = a + sx; st = 1; end
      6'd4:  begin tag = "R6"; ctl_flow = 1; if (a == b) npc = pc4 + (sx << 2); end
      6'd2:  begin tag = "R7"; ctl_flow = 1; npc = {pc4[31:28], ins[25:0], 2'b00}; end
      default: tag = "R9";
    endcase
    chk(pc_o === m_pc, ctl_flow ? tag : "R2", "pc", pc_o, m_pc);
    chk(rf_we_o === we, tag, "rf_we", 32'(rf_we_o), 32'(we));
    if (we) begin
      chk(rf_waddr_o === 5'(wa), tag, "rf_waddr", 32'(rf_waddr_o), 32'(wa));
      chk(rf_wdata_o === wd, tag, "rf_wdata", rf_wdata_o, wd);
    end
    chk(dm_we_o === st, tag, "dm_we", 32'(dm_we_o), 32'(st));
    if (st) begin
      chk(dm_addr_o === addr, tag, "dm_addr", dm_addr_o, addr);
      chk(dm_wdata_o === b, tag, "dm_wdata", dm_wdata_o, b);
    end
    if (we && wa != 0) m_rf[wa] = wd;
    if (st) m_dm[addr[7:2]] = b;
    m_pc = npc;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad_n++; total++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad_n);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; ld_we = 1'b0; ld_dmem = 1'b0; ld_addr = '0; ld_data = '0;
    for (int i = 0; i < 64; i++) begin m_im[i] = 32'hFC00_0000; m_dm[i] = '0; end
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    m_dm[0] = 32'd5; m_dm[1] = 32'hFFFF_FFFD; m_dm[2] = 32'h0F0F_00FF;
    m_dm[3] = 32'h00FF_0F0F; m_dm[9] = 32'hCAFE_0123;
    m_im[0]  = enc_i(6'd35, 0, 1, 16'h0000);
    m_im[1]  = enc_i(6'd35, 0, 2, 16'h0004);
    m_im[2]  = enc_i(6'd35, 0, 3, 16'h0008);
    m_im[3]  = enc_i(6'd35, 0, 4, 16'h000C);
    m_im[4]  = enc_r(1, 2, 5, 6'h20);
    m_im[5]  = enc_r(1, 2, 6, 6'h22);
    m_im[6]  = enc_r(3, 4, 7, 6'h24);
    m_im[7]  = enc_r(3, 4, 8, 6'h25);
    m_im[8]  = enc_r(2, 1, 9, 6'h2A);
    m_im[9]  = enc_r(1, 2, 10, 6'h2A);
    m_im[10] = enc_r(1, 1, 0, 6'h20);
    m_im[11] = enc_r(0, 1, 11, 6'h20);
    m_im[12] = enc_i(6'd43, 0, 6, 16'h0018);
    m_im[13] = enc_i(6'd35, 0, 12, 16'h0018);
    m_im[14] = enc_i(6'd35, 5, 13, 16'h0022);
    m_im[15] = enc_i(6'd43, 5, 1, 16'h002A);
    m_im[16] = enc_i(6'd4, 1, 11, 16'h0001);
    m_im[17] = enc_r(1, 1, 14, 6'h20);
    m_im[18] = enc_i(6'd4, 1, 2, 16'h0025);
    m_im[19] = 32'hFC22_1000;
    m_im[20] = enc_r(1, 1, 15, 6'h3F);
    m_im[21] = enc_j(26'd24);
    m_im[22] = enc_r(1, 1, 14, 6'h20);
    m_im[23] = enc_r(1, 1, 14, 6'h20);
    m_im[24] = enc_i(6'd35, 0, 15, 16'h002C);
    m_im[25] = enc_r(15, 13, 16, 6'h20);
    m_im[26] = enc_r(0, 1, 17, 6'h20);
    m_im[27] = enc_r(17, 9, 17, 6'h22);
    m_im[28] = enc_i(6'd4, 17, 0, 16'h0001);
    m_im[29] = enc_j(26'd27);
    m_im[30] = enc_i(6'd4, 0, 0, 16'hFFFF);
    // preload while reset is held
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); ld_we = 1'b1; ld_dmem = 1'b0; ld_addr = 6'(i); ld_data = m_im[i];
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = 6'(i); ld_data = m_dm[i];
    end
    @(negedge clk); ld_we = 1'b0;
    // R1: reset state
    chk(pc_o === 32'd0, "R1", "pc in reset", pc_o, 32'd0);
    chk(rf_we_o === 1'b0, "R1", "rf_we in reset", 32'(rf_we_o), 32'd0);
    chk(dm_we_o === 1'b0, "R1", "dm_we in reset", 32'(dm_we_o), 32'd0);
    m_pc = 32'd0;
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      step_cmp();
    end
    // R8: r0 stayed zero; r11 = r0 + 5
    chk(m_rf[11] === 32'd5, "R8", "model r11", m_rf[11], 32'd5);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad_n);
    $finish;
  end
endmodule